// File: doc/BRIEF.md
# Packed SIMD Shift Unit

This block shifts every lane of a 64-bit operand by one common count. Three operations are offered: logical left, logical right and arithmetic right. The lanes are 16, 32 or 64 bits wide, except that the arithmetic right shift has no 64-bit lane. Lanes never exchange bits. A count that exceeds the lane's top bit index does not wrap. A logical shift clears the lane. An arithmetic shift fills the lane with copies of its original sign bit.

The operation and lane size come from an 8-bit opcode byte. The immediate form also uses a 3-bit sub-operation field. A form-select input chooses where the count comes from: an unsigned 8-bit immediate, or a full 64-bit register operand. An encoding the unit does not recognise raises an illegal flag and yields zero. The result and the flag are registered, so they appear one clock after the inputs are presented.

Top module: `simd_shift_unit`

## Requirements
- R1: With `use_imm`=1, opcode 0x71, 0x72 and 0x73 select 16-, 32- and 64-bit lanes. `subop` 6 selects logical left, 2 selects logical right and 4 selects arithmetic right. The count is `imm`.
- R2: With `use_imm`=0, opcodes 0xF1/0xF2/0xF3 are logical left, 0xD1/0xD2/0xD3 are logical right and 0xE1/0xE2 are arithmetic right. The lanes are 16/32/64 bits in that order, and the count is `count_reg`.
- R3: Logical left shifts fill vacated low bits with zeros. Logical right shifts fill vacated high bits with zeros.
- R4: For a logical shift, a count greater than lane width minus one makes every lane all zeros.
- R5: An arithmetic right shift fills vacated high bits with the lane's original sign bit. A count greater than lane width minus one makes every bit of the lane equal to that sign bit.
- R6: A count of zero returns the operand unchanged. No bit moves from one lane into another.
- R7: Any encoding other than those in R1 and R2 sets `illegal` and gives a zero result. This includes arithmetic right on 64-bit lanes (0x73 with sub-op 4, and 0xE3).
- R8: In register-count form, all 64 count bits are compared with the limit, so any set upper bit is out of range. The immediate is unsigned, 0 to 255.
- R9: `result` and `illegal` are registered with one cycle of latency. A synchronous active-high reset clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| operand | input | 64 | Packed data to shift |
| count_reg | input | 64 | Count for the register-count form |
| imm | input | 8 | Count for the immediate form |
| use_imm | input | 1 | 1 selects the immediate form, 0 the register-count form |
| opcode | input | 8 | Opcode byte |
| subop | input | 3 | Sub-operation field (immediate form only) |
| result | output | 64 | Shifted data, registered |
| illegal | output | 1 | Unrecognised encoding, registered |

## Verification
The operands carry distinct bytes and opposite signs in neighbouring lanes. This shows whether bits leak between lanes, and whether the sign fill uses each lane's own top bit rather than the word's. The counts sit on each side of every lane limit (15/16, 31/32, 63/64, 255). This separates saturation from wrap-around and from plain shifting. Register counts with only a high bit set test the full-width compare. Every listed encoding and several unlisted neighbours are applied, so that a mis-decoded operation or lane size shows up as a wrong fill pattern or as a missing or spurious illegal flag.

// File: rtl/shft_pkg.sv
package shft_pkg;

    typedef enum logic [1:0] {
        OP_SLL  = 2'd0,
        OP_SRL  = 2'd1,
        OP_SRA  = 2'd2,
        OP_NONE = 2'd3
    } shift_op_e;

    typedef enum logic [1:0] {
        LANE_16 = 2'd0,
        LANE_32 = 2'd1,
        LANE_64 = 2'd2
    } lane_e;

    typedef struct packed {
        logic      legal;
        shift_op_e op;
        lane_e     lane;
    } shift_ctl_t;

    localparam logic [7:0] OPC_IMM_16 = 8'h71;
    localparam logic [7:0] OPC_IMM_32 = 8'h72;
    localparam logic [7:0] OPC_IMM_64 = 8'h73;
    localparam logic [7:0] OPC_SLL_BASE = 8'hF1;
    localparam logic [7:0] OPC_SRL_BASE = 8'hD1;
    localparam logic [7:0] OPC_SRA_BASE = 8'hE1;

    localparam logic [2:0] SUB_SLL = 3'd6;
    localparam logic [2:0] SUB_SRL = 3'd2;
    localparam logic [2:0] SUB_SRA = 3'd4;

    localparam int NUM_SIZES = 3;

    function automatic int lane_bits(lane_e l);
        case (l)
            LANE_16: return 16;
            LANE_32: return 32;
            default: return 64;
        endcase
    endfunction

    function automatic lane_e lane_of_low(logic [7:0] opc, logic [7:0] base);
        logic [7:0] d;
        d = opc - base;
        case (d)
            8'd0:    return LANE_16;
            8'd1:    return LANE_32;
            default: return LANE_64;
        endcase
    endfunction

endpackage

// File: rtl/shft_decode.sv
module shft_decode
    import shft_pkg::*;
(
    input  logic       use_imm,
    input  logic [7:0] opcode,
    input  logic [2:0] subop,
    output shift_ctl_t ctl
);

    logic lane_hit;

    always_comb begin
        ctl      = '{legal: 1'b0, op: OP_NONE, lane: LANE_16};
        lane_hit = 1'b0;
        if (use_imm) begin
            case (opcode)
                OPC_IMM_16: begin ctl.lane = LANE_16; lane_hit = 1'b1; end
                OPC_IMM_32: begin ctl.lane = LANE_32; lane_hit = 1'b1; end
                OPC_IMM_64: begin ctl.lane = LANE_64; lane_hit = 1'b1; end
                default:    lane_hit = 1'b0;
            endcase
            case (subop)
                SUB_SLL: ctl.op = OP_SLL;
                SUB_SRL: ctl.op = OP_SRL;
                SUB_SRA: ctl.op = OP_SRA;
                default: ctl.op = OP_NONE;
            endcase
        end else begin
            case (opcode)
                8'hF1, 8'hF2, 8'hF3: begin
                    ctl.op   = OP_SLL;
                    ctl.lane = lane_of_low(opcode, OPC_SLL_BASE);
                    lane_hit = 1'b1;
                end
                8'hD1, 8'hD2, 8'hD3: begin
                    ctl.op   = OP_SRL;
                    ctl.lane = lane_of_low(opcode, OPC_SRL_BASE);
                    lane_hit = 1'b1;
                end
                8'hE1, 8'hE2: begin
                    ctl.op   = OP_SRA;
                    ctl.lane = lane_of_low(opcode, OPC_SRA_BASE);
                    lane_hit = 1'b1;
                end
                default: lane_hit = 1'b0;
            endcase
        end
        ctl.legal = lane_hit && (ctl.op != OP_NONE)
                    && !(ctl.op == OP_SRA && ctl.lane == LANE_64);
    end

endmodule

// File: rtl/shft_count.sv
module shft_count
    import shft_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int IMM_W = 8,
    parameter int SH_W  = 6
) (
    input  logic             use_imm,
    input  logic [IMM_W-1:0] imm,
    input  logic [CNT_W-1:0] count_reg,
    input  lane_e            lane,
    output logic [SH_W-1:0]  sh,
    output logic             oor,
    output logic             is_zero
);

    logic [CNT_W-1:0] amount;
    logic [CNT_W-1:0] limit;

    always_comb begin
        amount  = use_imm ? {{(CNT_W-IMM_W){1'b0}}, imm} : count_reg;
        limit   = CNT_W'(lane_bits(lane) - 1);
        oor     = amount > limit;
        is_zero = (amount == '0);
        sh      = amount[SH_W-1:0];
    end

endmodule

// File: rtl/shft_lanes.sv
module shft_lanes
    import shft_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16,
    parameter int SH_W   = 6
) (
    input  logic [DATA_W-1:0] data,
    input  shift_op_e         op,
    input  logic [SH_W-1:0]   sh,
    input  logic              oor,
    output logic [DATA_W-1:0] res
);

    localparam int NUM_LANES = DATA_W / LANE_W;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        logic [LANE_W-1:0] d;
        logic [LANE_W-1:0] r;

        assign d = data[i*LANE_W +: LANE_W];

        always_comb begin
            case (op)
                OP_SLL:  r = oor ? '0 : (d << sh);
                OP_SRL:  r = oor ? '0 : (d >> sh);
                OP_SRA:  r = oor ? {LANE_W{d[LANE_W-1]}}
                                 : LANE_W'($signed(d) >>> sh);
                default: r = '0;
            endcase
        end

        assign res[i*LANE_W +: LANE_W] = r;

        // R5: a saturated arithmetic lane is all copies of its own sign bit
        always_comb begin
            if (op == OP_SRA && oor === 1'b1)
                a_r5_sign_saturate: assert (r == {LANE_W{d[LANE_W-1]}});
        end

        // R5: arithmetic shift keeps each lane's sign bit
        always_comb begin
            if (op == OP_SRA && ^d !== 1'bx && ^sh !== 1'bx)
                a_r5_sign_kept: assert (r[LANE_W-1] == d[LANE_W-1]);
        end
    end

endmodule

// File: rtl/simd_shift_unit.sv
module simd_shift_unit
    import shft_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] count_reg,
    input  logic [IMM_W-1:0]  imm,
    input  logic              use_imm,
    input  logic [7:0]        opcode,
    input  logic [2:0]        subop,
    output logic [DATA_W-1:0] result,
    output logic              illegal
);

    localparam int SH_W = $clog2(DATA_W);

    shift_ctl_t       ctl;
    logic [SH_W-1:0]  sh;
    logic             oor;
    logic             cnt_zero;
    logic [DATA_W-1:0] size_res [NUM_SIZES];
    logic [DATA_W-1:0] next_res;

    shft_decode u_decode (
        .use_imm (use_imm),
        .opcode  (opcode),
        .subop   (subop),
        .ctl     (ctl)
    );

    shft_count #(.CNT_W(DATA_W), .IMM_W(IMM_W), .SH_W(SH_W)) u_count (
        .use_imm   (use_imm),
        .imm       (imm),
        .count_reg (count_reg),
        .lane      (ctl.lane),
        .sh        (sh),
        .oor       (oor),
        .is_zero   (cnt_zero)
    );

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
        shft_lanes #(.DATA_W(DATA_W), .LANE_W(16 << g), .SH_W(SH_W)) u_lanes (
            .data (operand),
            .op   (ctl.op),
            .sh   (sh),
            .oor  (oor),
            .res  (size_res[g])
        );
    end

    always_comb begin
        case (ctl.lane)
            LANE_16: next_res = size_res[0];
            LANE_32: next_res = size_res[1];
            default: next_res = size_res[2];
        endcase
        if (!ctl.legal) next_res = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result  <= '0;
            illegal <= 1'b0;
        end else begin
            result  <= next_res;
            illegal <= !ctl.legal;
        end
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    a_r7_illegal_zero: assert property (@(posedge clk) disable iff (rst)
        illegal |-> result == '0);

    a_r6_zero_count_passes: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(ctl.legal && cnt_zero) |-> result == $past(operand));

    a_r4_logical_clear: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(ctl.legal && oor && ctl.op != OP_SRA) |-> result == '0);

    a_r9_reset_clears: assert property (@(posedge clk)
        $past(rst) && past_ok == 1'b0 && $past(past_ok) == 1'b0 |-> !illegal && result == '0);

endmodule

// File: tb/simd_shift_unit_test.sv
module simd_shift_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] operand;
    logic [63:0] count_reg;
    logic [7:0]  imm;
    logic        use_imm;
    logic [7:0]  opcode;
    logic [2:0]  subop;
    logic [63:0] result;
    logic        illegal;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    simd_shift_unit uut (
        .clk(clk), .rst(rst), .operand(operand), .count_reg(count_reg),
        .imm(imm), .use_imm(use_imm), .opcode(opcode), .subop(subop),
        .result(result), .illegal(illegal)
    );

    // Independent model: kind 0 left logical, 1 right logical, 2 right arithmetic
    function automatic logic [63:0] model(input logic ui, input logic [7:0] opc,
                                          input logic [2:0] so, input logic [7:0] im,
                                          input logic [63:0] cr, input logic [63:0] d,
                                          output logic bad);
        int kind = -1;
        int lb = 0;
        logic [63:0] amt;
        logic [63:0] r = '0;
        if (ui) begin
            if (opc == 8'h71) lb = 16; else if (opc == 8'h72) lb = 32;
            else if (opc == 8'h73) lb = 64;
            if (so == 3'd6) kind = 0; else if (so == 3'd2) kind = 1;
            else if (so == 3'd4) kind = 2;
            amt = {56'd0, im};
        end else begin
            if (opc >= 8'hF1 && opc <= 8'hF3) begin kind = 0; lb = 16 << (opc - 8'hF1); end
            if (opc >= 8'hD1 && opc <= 8'hD3) begin kind = 1; lb = 16 << (opc - 8'hD1); end
            if (opc >= 8'hE1 && opc <= 8'hE2) begin kind = 2; lb = 16 << (opc - 8'hE1); end
            amt = cr;
        end
        bad = (kind < 0) || (lb == 0) || (kind == 2 && lb == 64);
        if (bad) return '0;
        for (int base = 0; base < 64; base += lb) begin
            for (int b = 0; b < lb; b++) begin
                logic sgn;
                sgn = d[base + lb - 1];
                if (kind == 0)
                    r[base+b] = (amt >= 64'(lb) || 64'(b) < amt) ? 1'b0 : d[base + b - int'(amt)];
                else if (kind == 1)
                    r[base+b] = (amt >= 64'(lb) || 64'(b) + amt >= 64'(lb)) ? 1'b0
                                : d[base + b + int'(amt)];
                else
                    r[base+b] = (amt >= 64'(lb) || 64'(b) + amt >= 64'(lb)) ? sgn
                                : d[base + b + int'(amt)];
            end
        end
        return r;
    endfunction

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: result actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: illegal actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, check at the next falling edge (one register stage)
    task automatic run(input string tag, input logic ui, input logic [7:0] opc,
                       input logic [2:0] so, input logic [7:0] im,
                       input logic [63:0] cr, input logic [63:0] d);
        logic [63:0] exp;
        logic bad;
        @(negedge clk);
        use_imm = ui; opcode = opc; subop = so; imm = im; count_reg = cr; operand = d;
        exp = model(ui, opc, so, im, cr, d, bad);
        @(negedge clk);
        check64(tag, result, exp);
        check1(tag, illegal, bad);
    endtask

    localparam logic [63:0] PAT_A = 64'h8123_7F45_C0DE_0001;
    localparam logic [63:0] PAT_B = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] PAT_C = 64'h8000_0001_7FFF_FFFF;

    task automatic t_reset;
        run("R9 load", 1'b1, 8'h71, 3'd6, 8'd3, 64'd0, PAT_B);
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        check64("R9 reset result", result, 64'd0);
        check1("R9 reset illegal", illegal, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_imm_forms;
        for (int k = 0; k < 3; k++) begin
            run("R1 word", 1'b1, 8'h71, (k == 0) ? 3'd6 : (k == 1) ? 3'd2 : 3'd4, 8'd4, 64'd0, PAT_A);
            run("R1 dword", 1'b1, 8'h72, (k == 0) ? 3'd6 : (k == 1) ? 3'd2 : 3'd4, 8'd9, 64'd0, PAT_C);
        end
        run("R3 qword left", 1'b1, 8'h73, 3'd6, 8'd13, 64'd0, PAT_B);
        run("R3 qword right", 1'b1, 8'h73, 3'd2, 8'd61, 64'd0, PAT_B);
        run("R5 word sign fill", 1'b1, 8'h71, 3'd4, 8'd7, 64'd0, PAT_A);
    endtask

    task automatic t_reg_forms;
        logic [7:0] ops [8] = '{8'hF1, 8'hF2, 8'hF3, 8'hD1, 8'hD2, 8'hD3, 8'hE1, 8'hE2};
        foreach (ops[i]) begin
            run("R2 reg form", 1'b0, ops[i], 3'd0, 8'hFF, 64'd5, PAT_A);
            run("R2 reg form b", 1'b0, ops[i], 3'd6, 8'd0, 64'd1, PAT_C);
        end
    endtask

    task automatic t_saturation;
        logic [7:0] cnts [7] = '{8'd15, 8'd16, 8'd31, 8'd32, 8'd63, 8'd64, 8'd255};
        foreach (cnts[i]) begin
            run("R4 word left", 1'b1, 8'h71, 3'd6, cnts[i], 64'd0, PAT_B);
            run("R4 dword right", 1'b1, 8'h72, 3'd2, cnts[i], 64'd0, PAT_B);
            run("R4 qword right", 1'b1, 8'h73, 3'd2, cnts[i], 64'd0, PAT_B);
            run("R5 word arith", 1'b1, 8'h71, 3'd4, cnts[i], 64'd0, PAT_A);
            run("R5 dword arith", 1'b1, 8'h72, 3'd4, cnts[i], 64'd0, PAT_C);
        end
    endtask

    task automatic t_wide_count;
        run("R8 high bit left", 1'b0, 8'hF1, 3'd0, 8'd0, 64'h0000_0100_0000_0002, PAT_B);
        run("R8 top bit arith", 1'b0, 8'hE2, 3'd0, 8'd0, 64'h8000_0000_0000_0001, PAT_C);
        run("R8 high bit qword", 1'b0, 8'hD3, 3'd0, 8'd0, 64'h0000_0000_0001_0000, PAT_B);
        run("R8 imm unsigned 200", 1'b1, 8'h71, 3'd4, 8'd200, 64'd0, PAT_A);
        run("R8 imm 128 qword", 1'b1, 8'h73, 3'd6, 8'd128, 64'd0, PAT_B);
    endtask

    task automatic t_zero_and_lanes;
        run("R6 zero imm", 1'b1, 8'h71, 3'd4, 8'd0, 64'd0, PAT_A);
        run("R6 zero reg", 1'b0, 8'hD2, 3'd0, 8'd9, 64'd0, PAT_B);
        run("R6 no crossing left", 1'b1, 8'h71, 3'd6, 8'd1, 64'd0, 64'h8000_8000_8000_8000);
        run("R6 no crossing right", 1'b1, 8'h72, 3'd2, 8'd1, 64'd0, 64'h0000_0001_0000_0001);
        check64("R6 lane isolation value", result, 64'd0);
    endtask

    task automatic t_illegal;
        run("R7 qword arith imm", 1'b1, 8'h73, 3'd4, 8'd1, 64'd0, PAT_B);
        run("R7 qword arith reg", 1'b0, 8'hE3, 3'd0, 8'd0, 64'd1, PAT_B);
        run("R7 bad opcode imm", 1'b1, 8'h70, 3'd6, 8'd1, 64'd0, PAT_B);
        run("R7 bad subop", 1'b1, 8'h72, 3'd3, 8'd1, 64'd0, PAT_B);
        run("R7 imm opcode as reg", 1'b0, 8'h71, 3'd6, 8'd1, 64'd1, PAT_B);
        run("R7 reg opcode as imm", 1'b1, 8'hF1, 3'd6, 8'd1, 64'd1, PAT_B);
        run("R7 recover", 1'b1, 8'h72, 3'd6, 8'd1, 64'd0, PAT_B);
    endtask

    task automatic t_latency;
        logic [63:0] held;
        run("R9 first", 1'b1, 8'h71, 3'd6, 8'd2, 64'd0, PAT_B);
        held = result;
        @(negedge clk);
        use_imm = 1'b1; opcode = 8'h71; subop = 3'd2; imm = 8'd2; operand = PAT_A;
        #5;
        check64("R9 held before edge", result, held);
        @(negedge clk);
        check64("R9 after edge", result, 64'h2048_1FD1_3037_0000);
    endtask

    initial begin
        rst = 1'b1; operand = '0; count_reg = '0; imm = '0;
        use_imm = 1'b1; opcode = 8'h71; subop = 3'd6;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_imm_forms();
        t_reg_forms();
        t_saturation();
        t_wide_count();
        t_zero_and_lanes();
        t_illegal();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule